// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a simple register bus. Software loads a 16-bit compare value, selects one of three count sources and a power-of-four prescale, and then enables counting. Each rising edge of the chosen source is synchronised into the bus clock and passed through the prescaler. Every prescaled tick advances an up-counter by one. When the counter already equals the compare value at a tick, the block raises a one-cycle reset request and freezes the count.

Software keeps the system alive by writing zero into the live counter register, which restarts the count. Writing any other value preloads the counter. Control, compare and counter are meant to be reprogrammed while counting is disabled. All counting, comparing and the reset pulse run in the bus clock domain.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all four registers read zero, counting is disabled and `reset_req` is low.
- R2: Writes take effect when `bus_sel`, `bus_we` are high and `bus_addr[1:0]` is 0. `bus_addr[3:2]` picks the register: 0 = compare (16 bits), 1 = enable (bit 0), 2 = counter (16 bits, live count), 3 = control (bits [5:0]). Reads return current contents, with unused bits read as zero.
- R3: Control bits [2:0] select the source: bit 0 `src_periph`, bit 1 `src_rtc`, bit 2 `src_ext`. A rising source edge sampled at clock edge k can update the counter at edge k+2 at the earliest.
- R4: A source field of zero, or with more than one bit set, produces no ticks, and the counter does not move.
- R5: Control bits [5:3] hold a prescale code. Codes 0 to 5 give one tick per 1, 4, 16, 64, 256 and 1024 source edges. Codes 6 and 7 behave as 1024.
- R6: The counter advances by one per tick only while enable bit 0 is 1. While disabled, it holds its value.
- R7: A tick that finds the counter equal to the compare value drives `reset_req` high for exactly one clock. The counter then holds at that value, with no further pulses, until the counter is written or counting is disabled. A count of 0xFFFF with compare 0xFFFF does not wrap.
- R8: A counter write loads the written value and re-arms the compare. Writing 0 is the keep-alive kick. A counter write wins over a tick in the same cycle.
- R9: Any control write returns the prescaler's internal divider to zero, so the new division starts at a clean phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| src_periph | input | 1 | Peripheral count source, sampled |
| src_rtc | input | 1 | Real-time count source, sampled |
| src_ext | input | 1 | External count source, sampled |
| reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The three sources toggle at different rates, so a wrong source select shows up as a wrong tick spacing. Divide-by-1, 4, 16 and 1024 are each run, so an off-by-one prescale limit is exposed, and code 7 is kept apart from code 5. Invalid source fields, a disabled counter and a 0xFFFF compare probe stalls and wrap-around. Kicks after a fired timeout show the re-arm behaviour. A control rewrite in the middle of a divide phase shows whether the divider is cleared. A behavioural model compares `reset_req` and the addressed read data every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned WD_CNT_W    = 16;
    localparam int unsigned WD_SRC_N    = 3;
    localparam int unsigned WD_CODE_W   = 3;
    localparam int unsigned WD_MAX_CODE = 5;

    typedef enum logic [1:0] {
        WREG_CMP = 2'd0,
        WREG_EN  = 2'd1,
        WREG_CNT = 2'd2,
        WREG_CTL = 2'd3
    } wreg_e;
endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = src_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = sync_q.s2[g] & ~sync_q.s3[g];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]); // R3
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              edge_i,
    output logic              tick_o
);
    localparam int unsigned DIV_W = 2 * MAX_CODE;

    function automatic logic [DIV_W-1:0] limit_of(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] lim;
        int               c;
        c   = (int'(code) > int'(MAX_CODE)) ? int'(MAX_CODE) : int'(code);
        lim = '0;
        for (int i = 0; i < int'(DIV_W); i++) begin
            if (i < 2 * c) lim[i] = 1'b1;
        end
        return lim;
    endfunction

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_t;

    ps_t              ps_d, ps_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        lim    = limit_of(code_i);
        at_lim = (ps_q.div == lim);
        tick_o = run_i && edge_i && at_lim;
        ps_d   = ps_q;
        if (clr_i || !run_i) begin
            ps_d.div = '0;
        end else if (edge_i) begin
            ps_d.div = at_lim ? '0 : ps_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    AST_CLR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ps_q.div == '0)); // R9
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (ps_q.div == '0)); // R5
endmodule

// File: rtl/wdog_count_cmp.sv
module wdog_count_cmp #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic [W-1:0] cmp_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         req_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         fired;
        logic         req;
    } cc_t;

    cc_t cc_d, cc_q;

    always_comb begin
        cc_d     = cc_q;
        cc_d.req = 1'b0;
        if (!en_i) cc_d.fired = 1'b0;
        if (ld_i) begin
            cc_d.cnt   = ld_val_i;
            cc_d.fired = 1'b0;
        end else if (tick_i && !cc_q.fired) begin
            if (cc_q.cnt == cmp_i) begin
                cc_d.fired = 1'b1;
                cc_d.req   = 1'b1;
            end else begin
                cc_d.cnt = cc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc_q <= '0;
        else        cc_q <= cc_d;
    end

    assign cnt_o = cc_q.cnt;
    assign req_o = cc_q.req;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o); // R7
    AST_HOLD_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_q.fired && en_i && !ld_i) |=> $stable(cnt_o)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !ld_i) |=> $stable(cnt_o)); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_o == $past(ld_val_i))); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W    = WD_CNT_W,
    parameter int unsigned SRC_N    = WD_SRC_N,
    parameter int unsigned CODE_W   = WD_CODE_W,
    parameter int unsigned MAX_CODE = WD_MAX_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             src_periph,
    input  logic             src_rtc,
    input  logic             src_ext,
    output logic             reset_req
);
    localparam int unsigned CTL_W = SRC_N + CODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             en;
        logic [CTL_W-1:0] ctl;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             wr_hit;
    wreg_e            reg_idx;
    logic             cnt_wr, ctl_wr;
    logic [SRC_N-1:0] src_vec, rise, src_sel;
    logic             src_ok, src_edge, tick;
    logic [CNT_W-1:0] cnt;

    assign src_vec = {src_ext, src_rtc, src_periph};
    assign src_sel = rg_q.ctl[SRC_N-1:0];

    always_comb begin
        wr_hit  = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
        reg_idx = wreg_e'(bus_addr[3:2]);
        cnt_wr  = wr_hit && (reg_idx == WREG_CNT);
        ctl_wr  = wr_hit && (reg_idx == WREG_CTL);
        rg_d    = rg_q;
        if (wr_hit) begin
            case (reg_idx)
                WREG_CMP: rg_d.cmp = bus_wdata;
                WREG_EN:  rg_d.en  = bus_wdata[0];
                WREG_CTL: rg_d.ctl = bus_wdata[CTL_W-1:0];
                default:  rg_d     = rg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        src_ok   = ($countones(src_sel) == 1);
        src_edge = src_ok && ((src_sel & rise) != '0);
    end

    always_comb begin
        case (reg_idx)
            WREG_CMP: bus_rdata = rg_q.cmp;
            WREG_EN:  bus_rdata = {{(CNT_W-1){1'b0}}, rg_q.en};
            WREG_CNT: bus_rdata = cnt;
            default:  bus_rdata = {{(CNT_W-CTL_W){1'b0}}, rg_q.ctl};
        endcase
    end

    wdog_edge_sync #(.N(SRC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_vec),
        .rise_o (rise)
    );

    wdog_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (rg_q.en),
        .clr_i  (ctl_wr),
        .code_i (rg_q.ctl[CTL_W-1:SRC_N]),
        .edge_i (src_edge),
        .tick_o (tick)
    );

    wdog_count_cmp #(.W(CNT_W)) u_cc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (rg_q.en),
        .tick_i   (tick),
        .cmp_i    (rg_q.cmp),
        .ld_i     (cnt_wr),
        .ld_val_i (bus_wdata),
        .cnt_o    (cnt),
        .req_o    (reset_req)
    );

    AST_BAD_SRC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot(src_sel) && !cnt_wr) |=> $stable(cnt)); // R4
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rg_q.en) |=> !reset_req); // R6
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h8;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        src_periph = 1'b0, src_rtc = 1'b0, src_ext = 1'b0;
    logic        reset_req;

    int tests = 0, fails = 0, pulses = 0, cyc = 0;

    always #2.5 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_periph(src_periph), .src_rtc(src_rtc), .src_ext(src_ext),
        .reset_req(reset_req)
    );

    // source stimulus: periph edge every 4 cycles, rtc every 6, ext every 2
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            src_ext = ~src_ext;
            if (ph % 2 == 0) src_periph = ~src_periph;
            if (ph % 3 == 0) src_rtc = ~src_rtc;
        end
    end

    // behavioural reference model
    logic [15:0] m_cmp, m_cnt;
    logic [5:0]  m_ctl;
    logic        m_en, m_fired, m_req;
    logic [2:0]  m_s1, m_s2, m_s3;
    int          m_div;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmp = 0; m_cnt = 0; m_ctl = 0; m_en = 0; m_fired = 0; m_req = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_div = 0;
        end else begin
            logic [2:0] rise, sel;
            logic valid, hit, tick, wr;
            int code, lim, ridx;
            rise  = m_s2 & ~m_s3;
            sel   = m_ctl[2:0];
            valid = (sel == 3'b001) || (sel == 3'b010) || (sel == 3'b100);
            hit   = valid && ((sel & rise) != 3'b000);
            code  = int'(m_ctl[5:3]);
            if (code > 5) code = 5;
            lim   = (1 << (2 * code)) - 1;
            tick  = m_en && hit && (m_div == lim);
            wr    = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
            ridx  = int'(bus_addr[3:2]);
            if ((wr && ridx == 3) || !m_en) m_div = 0;
            else if (hit) m_div = (m_div == lim) ? 0 : m_div + 1;
            m_req = 1'b0;
            if (!m_en) m_fired = 1'b0;
            if (wr && ridx == 2) begin
                m_cnt = bus_wdata; m_fired = 1'b0;
            end else if (tick && !m_fired) begin
                if (m_cnt == m_cmp) begin m_fired = 1'b1; m_req = 1'b1; end
                else m_cnt = m_cnt + 16'd1;
            end
            if (wr && ridx == 0) m_cmp = bus_wdata;
            if (wr && ridx == 1) m_en = bus_wdata[0];
            if (wr && ridx == 3) m_ctl = bus_wdata[5:0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = {src_ext, src_rtc, src_periph};
        end
    end

    function automatic logic [15:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_cmp;
            2'd1: return {15'd0, m_en};
            2'd2: return m_cnt;
            default: return {10'd0, m_ctl};
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(posedge clk);
        cyc++;
        #1;
        chk("R7 reset_req", int'(reset_req), int'(m_req));
        chk("R2 read data", int'(bus_rdata), int'(model_read(bus_addr)));
        if (reset_req === 1'b1) pulses++;
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 4'h8; bus_wdata = 16'h0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        bus_addr = a;
        #1 d = int'(bus_rdata);
        bus_addr = 4'h8;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, v0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'h0, v); chk("R1 compare", v, 0);
        rd(4'h4, v); chk("R1 enable", v, 0);
        rd(4'h8, v); chk("R1 counter", v, 0);
        rd(4'hC, v); chk("R1 control", v, 0);
        chk("R1 reset_req", int'(reset_req), 0);
        // R2 readback and masking
        wr(4'h0, 16'hA5C3); rd(4'h0, v); chk("R2 compare", v, 16'hA5C3);
        wr(4'hC, 16'hFFFF); rd(4'hC, v); chk("R2 control mask", v, 16'h003F);
        wr(4'hC, 16'h0000);
        wr(4'h4, 16'hFFFF); rd(4'h4, v); chk("R2 enable bit", v, 1);
        wr(4'h4, 16'h0000);
        // R3 periph source, divide 1, compare 5
        wr(4'h8, 16'h0); wr(4'hC, 16'h0001); wr(4'h0, 16'd5); wr(4'h4, 16'h1);
        repeat (80) @(negedge clk);
        chk("R3 periph timeout pulse", pulses, 1);
        rd(4'h8, v); chk("R7 hold at compare", v, 5);
        repeat (40) @(negedge clk);
        chk("R7 single pulse", pulses, 1);
        // R8 kick
        wr(4'h8, 16'h0); rd(4'h8, v); chk("R8 kick clears", v, 0);
        repeat (80) @(negedge clk);
        chk("R8 re-armed pulse", pulses, 2);
        // R6 disable holds
        wr(4'h8, 16'h2); wr(4'h4, 16'h0); rd(4'h8, v0);
        repeat (50) @(negedge clk);
        rd(4'h8, v); chk("R6 disabled holds", v, v0);
        // R4 invalid sources
        wr(4'h8, 16'h0); wr(4'hC, 16'h0003); wr(4'h4, 16'h1);
        repeat (60) @(negedge clk);
        rd(4'h8, v); chk("R4 two-hot source", v, 0);
        wr(4'hC, 16'h0000);
        repeat (60) @(negedge clk);
        rd(4'h8, v); chk("R4 empty source", v, 0);
        // R3 and R5 rtc source, divide 4
        wr(4'h4, 16'h0); wr(4'hC, 16'h000A); wr(4'h0, 16'd3); wr(4'h8, 16'h0);
        p0 = pulses; wr(4'h4, 16'h1);
        repeat (150) @(negedge clk);
        chk("R5 rtc div4 pulse", pulses, p0 + 1);
        // R5 code 7 acts as divide 1024 on ext
        wr(4'h4, 16'h0); wr(4'hC, 16'h003C); wr(4'h0, 16'd2); wr(4'h8, 16'h0);
        p0 = pulses; wr(4'h4, 16'h1);
        repeat (4600) @(negedge clk);
        rd(4'h8, v); chk("R5 code7 count", v, 2);
        chk("R5 code7 no pulse yet", pulses, p0);
        repeat (2100) @(negedge clk);
        chk("R5 code7 pulse", pulses, p0 + 1);
        // R5 code 5 divide 1024
        wr(4'h4, 16'h0); wr(4'hC, 16'h002C); wr(4'h0, 16'd1); wr(4'h8, 16'h0);
        p0 = pulses; wr(4'h4, 16'h1);
        repeat (1900) @(negedge clk);
        rd(4'h8, v); chk("R5 code5 count", v, 0);
        repeat (2600) @(negedge clk);
        chk("R5 code5 pulse", pulses, p0 + 1);
        // R7 top of range, no wrap
        wr(4'h4, 16'h0); wr(4'hC, 16'h0004); wr(4'h0, 16'hFFFF); wr(4'h8, 16'hFFFD);
        p0 = pulses; wr(4'h4, 16'h1);
        repeat (40) @(negedge clk);
        chk("R7 max compare pulse", pulses, p0 + 1);
        rd(4'h8, v); chk("R7 no wrap", v, 16'hFFFF);
        // R9 control write clears divider phase (ext, divide 16)
        wr(4'h4, 16'h0); wr(4'hC, 16'h0014); wr(4'h0, 16'd100); wr(4'h8, 16'h0);
        wr(4'h4, 16'h1);
        repeat (21) @(negedge clk);
        wr(4'hC, 16'h0014); rd(4'h8, v0);
        repeat (26) @(negedge clk);
        rd(4'h8, v); chk("R9 phase restarted", v, v0);
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule